// File: doc/BRIEF.md
# Programmable Fixed-Cycle Countdown Timer

The block is a 12-bit down-counter that raises a periodic interrupt event. Software loads a preset (1 to 4095, with 0 taken as 4096) through two byte-wide write strobes. It then picks one of four time bases with a 2-bit select field and raises the run bit. Each tick of the selected base lowers the count by one. The step from 1 to 0 is the event, and at that step the counter reloads the preset by itself, so events repeat every preset ticks. Two of the time bases are the calendar's second and minute rollover strobes, so in those modes both the count steps and the events line up with calendar updates.

Each event sets a sticky flag that stays set until software clears it. When the interrupt enable is set, the event also drives an active-low interrupt request. The request releases by itself after a fixed number of 128 Hz ticks (one tick by default, about 7.8 ms). Generating the tick strobes and decoding the bus are handled outside this block.

Top module: `cycle_timer`

## Requirements
- R1: While rst_ni is low, count_o is 0, flag_o is 0 and irq_no is 1.
- R2: A cycle with preset_lo_we_i high stores wdata_i[7:0] into preset bits 7:0. A cycle with preset_hi_we_i high stores wdata_i[3:0] into preset bits 11:8, and wdata_i[7:4] is ignored. Both take effect at the next clock edge.
- R3: A 0-to-1 change of run_i loads the preset into count_o, visible one cycle later. A source tick in that same cycle is ignored.
- R4: src_sel_i chooses the time base: 0 = tick_4k_i, 1 = tick_64_i, 2 = sec_roll_i, 3 = min_roll_i. Ticks on the unselected inputs leave the count unchanged.
- R5: While run_i is high, each selected tick lowers count_o by one, visible one cycle later.
- R6: A selected tick while count_o is 1 is an event, and count_o reloads the preset in the next cycle.
- R7: A preset of 0 counts as 4096. From 0 the count wraps to 4095 without an event, so one event occurs every 4096 ticks.
- R8: While run_i is low, count_o holds its value and no event occurs.
- R9: flag_o becomes 1 in the cycle after an event and stays 1 until a cycle with flag_clr_i high. If an event and a clear fall in the same cycle, the flag is set.
- R10: If irq_en_i is high during an event, irq_no goes low in the next cycle. irq_no returns high in the cycle after the PULSE_TICKS-th tick_128_i that arrives after the event.
- R11: While irq_en_i is low, irq_no is high one cycle later and events do not pull it low, but flag_o is still set.
- R12: Clearing the flag does not release irq_no.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_4k_i | input | 1 | 4096 Hz tick strobe |
| tick_64_i | input | 1 | 64 Hz tick strobe |
| sec_roll_i | input | 1 | Calendar second rollover strobe |
| min_roll_i | input | 1 | Calendar minute rollover strobe |
| tick_128_i | input | 1 | 128 Hz strobe that times the interrupt pulse |
| preset_lo_we_i | input | 1 | Write strobe for preset low byte |
| preset_hi_we_i | input | 1 | Write strobe for preset high nibble |
| wdata_i | input | 8 | Write data for the preset |
| run_i | input | 1 | Run bit; a rising edge starts from the preset |
| src_sel_i | input | 2 | Time-base select |
| flag_clr_i | input | 1 | Clears the sticky flag |
| irq_en_i | input | 1 | Interrupt enable |
| count_o | output | 12 | Current count |
| flag_o | output | 1 | Sticky event flag |
| irq_no | output | 1 | Interrupt request, active low |

## Verification
Every result is one register deep. The count, the flag and the interrupt level all change in the cycle after the edge that samples the tick, start, clear or enable that causes them. The bench drives inputs just after a rising edge. At every falling edge it compares all three outputs with a behavioural reference model that advanced at the preceding rising edge. Directed checks read the outputs two nanoseconds after the edge that consumed the stimulus, which is exactly one register stage later.

// File: rtl/cycle_timer_pkg.sv
package cycle_timer_pkg;
  typedef enum logic [1:0] {
    SRC_4K  = 2'd0,
    SRC_64  = 2'd1,
    SRC_SEC = 2'd2,
    SRC_MIN = 2'd3
  } src_e;
  localparam int unsigned NUM_SRC = 4;
endpackage

// File: rtl/cycle_timer_src_mux.sv
module cycle_timer_src_mux
  import cycle_timer_pkg::*;
(
  input  logic [NUM_SRC-1:0] ticks_i,
  input  src_e               sel_i,
  output logic               step_o
);
  assign step_o = ticks_i[sel_i];
endmodule

// File: rtl/cycle_timer_core.sv
module cycle_timer_core #(
  parameter int unsigned CNT_W  = 12,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lo_we_i,
  input  logic              hi_we_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              run_i,
  input  logic              step_i,
  output logic [CNT_W-1:0]  count_o,
  output logic [CNT_W-1:0]  preset_o,
  output logic              event_o
);
  localparam int unsigned HI_W = CNT_W - BYTE_W;

  logic [CNT_W-1:0] preset_q, count_q;
  logic             run_q, start;
  logic             unused_wdata;

  assign unused_wdata = ^wdata_i[BYTE_W-1:HI_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      preset_q <= '0;
    end else begin
      if (lo_we_i) preset_q[BYTE_W-1:0]     <= wdata_i;
      if (hi_we_i) preset_q[CNT_W-1:BYTE_W] <= wdata_i[HI_W-1:0];
    end
  end

  assign start   = run_i & ~run_q;
  // terminal step; the start cycle never counts
  assign event_o = run_i & run_q & step_i & (count_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      count_q <= '0;
    end else begin
      run_q <= run_i;
      if (start)                count_q <= preset_q;
      else if (event_o)         count_q <= preset_q;
      else if (run_i && step_i) count_q <= count_q - CNT_W'(1); // 0 wraps: preset 0 acts as 4096
    end
  end

  assign count_o  = count_q;
  assign preset_o = preset_q;
endmodule

// File: rtl/cycle_timer_irq.sv
module cycle_timer_irq #(
  parameter int unsigned PULSE_TICKS = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic event_i,
  input  logic clr_i,
  input  logic en_i,
  input  logic tick_128_i,
  output logic flag_o,
  output logic irq_no
);
  localparam int unsigned PC_W = (PULSE_TICKS > 1) ? $clog2(PULSE_TICKS) : 1;

  logic            flag_q, active_q;
  logic [PC_W-1:0] pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      flag_q <= 1'b0;
    else if (event_i) flag_q <= 1'b1;
    else if (clr_i)   flag_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      pc_q     <= '0;
    end else if (!en_i) begin
      active_q <= 1'b0;
      pc_q     <= '0;
    end else if (event_i) begin
      active_q <= 1'b1;
      pc_q     <= '0;
    end else if (active_q && tick_128_i) begin
      if (pc_q == PC_W'(PULSE_TICKS - 1)) begin
        active_q <= 1'b0;
        pc_q     <= '0;
      end else begin
        pc_q <= pc_q + PC_W'(1);
      end
    end
  end

  assign flag_o = flag_q;
  assign irq_no = ~active_q;
endmodule

// File: rtl/cycle_timer.sv
module cycle_timer
  import cycle_timer_pkg::*;
#(
  parameter int unsigned CNT_W       = 12,
  parameter int unsigned BYTE_W      = 8,
  parameter int unsigned PULSE_TICKS = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_4k_i,
  input  logic              tick_64_i,
  input  logic              sec_roll_i,
  input  logic              min_roll_i,
  input  logic              tick_128_i,
  input  logic              preset_lo_we_i,
  input  logic              preset_hi_we_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              run_i,
  input  logic [1:0]        src_sel_i,
  input  logic              flag_clr_i,
  input  logic              irq_en_i,
  output logic [CNT_W-1:0]  count_o,
  output logic              flag_o,
  output logic              irq_no
);
  logic [NUM_SRC-1:0] ticks;
  logic               step_w, event_w;
  logic [CNT_W-1:0]   preset_w;

  assign ticks = {min_roll_i, sec_roll_i, tick_64_i, tick_4k_i};

  cycle_timer_src_mux u_mux (
    .ticks_i (ticks),
    .sel_i   (src_e'(src_sel_i)),
    .step_o  (step_w)
  );

  cycle_timer_core #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .lo_we_i  (preset_lo_we_i),
    .hi_we_i  (preset_hi_we_i),
    .wdata_i  (wdata_i),
    .run_i    (run_i),
    .step_i   (step_w),
    .count_o  (count_o),
    .preset_o (preset_w),
    .event_o  (event_w)
  );

  cycle_timer_irq #(.PULSE_TICKS(PULSE_TICKS)) u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .event_i    (event_w),
    .clr_i      (flag_clr_i),
    .en_i       (irq_en_i),
    .tick_128_i (tick_128_i),
    .flag_o     (flag_o),
    .irq_no     (irq_no)
  );
endmodule

// File: rtl/cycle_timer_chk.sv
module cycle_timer_chk #(
  parameter int unsigned CNT_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             run_i,
  input logic             flag_clr_i,
  input logic             irq_en_i,
  input logic             event_i,
  input logic [CNT_W-1:0] preset_i,
  input logic [CNT_W-1:0] count_o,
  input logic             flag_o,
  input logic             irq_no
);
  AST_START_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_i) |=> (count_o == $past(preset_i))); // R3
  AST_EVENT_RELOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_i |=> (count_o == $past(preset_i))); // R6
  AST_HOLD_STOPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(count_o)); // R8
  AST_NO_EVENT_STOPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> !event_i); // R8
  AST_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_i |=> flag_o); // R9
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !flag_clr_i) |=> flag_o); // R9
  AST_IRQ_ASSERT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (event_i && irq_en_i) |=> !irq_no); // R10
  AST_IRQ_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_no) |-> $past(event_i)); // R10
  AST_IRQ_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_en_i |=> irq_no); // R11
endmodule

bind cycle_timer cycle_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .run_i      (run_i),
  .flag_clr_i (flag_clr_i),
  .irq_en_i   (irq_en_i),
  .event_i    (event_w),
  .preset_i   (preset_w),
  .count_o    (count_o),
  .flag_o     (flag_o),
  .irq_no     (irq_no)
);

// File: tb/cycle_timer_tb.sv
module cycle_timer_tb;
  localparam int PULSE = 1;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tick_4k = 0, tick_64 = 0, sec_roll = 0, min_roll = 0, tick_128 = 0;
  logic lo_we = 0, hi_we = 0, run = 0, flag_clr = 0, irq_en = 0;
  logic [7:0]  wdata = '0;
  logic [1:0]  sel = '0;
  logic [11:0] count;
  logic        flag, irq_n;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cycle_timer #(.PULSE_TICKS(PULSE)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_4k_i(tick_4k), .tick_64_i(tick_64),
    .sec_roll_i(sec_roll), .min_roll_i(min_roll), .tick_128_i(tick_128),
    .preset_lo_we_i(lo_we), .preset_hi_we_i(hi_we), .wdata_i(wdata),
    .run_i(run), .src_sel_i(sel), .flag_clr_i(flag_clr), .irq_en_i(irq_en),
    .count_o(count), .flag_o(flag), .irq_no(irq_n)
  );

  // behavioural reference
  int m_pre = 0, m_cnt = 0, m_flag = 0, m_irq = 0, m_pc = 0;
  bit m_runq = 0;
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_pre = 0; m_cnt = 0; m_flag = 0; m_irq = 0; m_pc = 0; m_runq = 0;
    end else begin
      bit tk, ev;
      tk = (sel == 0) ? tick_4k : (sel == 1) ? tick_64 : (sel == 2) ? sec_roll : min_roll;
      ev = 0;
      if (run && !m_runq) m_cnt = m_pre;
      else if (run && tk) begin
        if (m_cnt == 1) begin ev = 1; m_cnt = m_pre; end
        else m_cnt = (m_cnt + 4095) % 4096;
      end
      m_runq = run;
      if (lo_we) m_pre = (m_pre & 'hF00) | wdata;
      if (hi_we) m_pre = (m_pre & 'h0FF) | ((wdata & 'hF) << 8);
      if (ev) m_flag = 1; else if (flag_clr) m_flag = 0;
      if (!irq_en) begin m_irq = 0; m_pc = 0; end
      else if (ev) begin m_irq = 1; m_pc = 0; end
      else if (m_irq == 1 && tick_128) begin
        if (m_pc == PULSE - 1) begin m_irq = 0; m_pc = 0; end
        else m_pc++;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_ni && !done) begin
      n_chk++;
      if (int'(count) != m_cnt) begin
        n_fail++; $display("FAIL R5 model count act=%0d exp=%0d", count, m_cnt);
      end
      n_chk++;
      if (int'(flag) != m_flag) begin
        n_fail++; $display("FAIL R9 model flag act=%0d exp=%0d", flag, m_flag);
      end
      n_chk++;
      if (int'(irq_n) != 1 - m_irq) begin
        n_fail++; $display("FAIL R10 model irq_n act=%0d exp=%0d", irq_n, 1 - m_irq);
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #2;
  endtask

  task automatic t4k();  tick_4k = 1;  cyc(); tick_4k = 0;  endtask
  task automatic t64();  tick_64 = 1;  cyc(); tick_64 = 0;  endtask
  task automatic tsec(); sec_roll = 1; cyc(); sec_roll = 0; endtask
  task automatic tmin(); min_roll = 1; cyc(); min_roll = 0; endtask
  task automatic t128(); tick_128 = 1; cyc(); tick_128 = 0; endtask
  task automatic clr();  flag_clr = 1; cyc(); flag_clr = 0; endtask

  task automatic wr_preset(logic [7:0] lo, logic [7:0] hi);
    wdata = lo; lo_we = 1; cyc(); lo_we = 0;
    wdata = hi; hi_we = 1; cyc(); hi_we = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    finish_run();
  end

  initial begin
    repeat (3) cyc();
    chk("R1 count in reset", count, 0);
    chk("R1 flag in reset", flag, 0);
    chk("R1 irq_n in reset", irq_n, 1);
    rst_ni = 1; cyc();
    irq_en = 1;

    wr_preset(8'h05, 8'hA3);
    sel = 0; run = 1; cyc();
    chk("R2 R3 preset load", count, 'h305);
    t64();  chk("R4 unselected tick", count, 'h305);
    t4k();  chk("R5 decrement", count, 'h304);

    run = 0; cyc();
    wr_preset(8'h03, 8'h00);
    run = 1; cyc();
    chk("R3 restart load", count, 3);
    t4k(); t4k();
    chk("R5 count at one", count, 1);
    t4k();
    chk("R6 reload", count, 3);
    chk("R9 flag set", flag, 1);
    chk("R10 irq low", irq_n, 0);
    cyc(); cyc();
    chk("R10 irq held", irq_n, 0);
    t128();
    chk("R10 irq released", irq_n, 1);
    chk("R9 flag sticky", flag, 1);
    clr();
    chk("R9 flag cleared", flag, 0);

    sel = 2; cyc();
    t4k();
    chk("R4 4k ignored in sec mode", count, 3);
    tsec(); tsec(); tsec();
    chk("R4 sec mode event", flag, 1);
    chk("R10 irq sec event", irq_n, 0);
    clr();
    chk("R12 clear keeps irq", irq_n, 0);
    irq_en = 0; cyc();
    chk("R11 disable releases", irq_n, 1);
    sel = 3; cyc();
    tmin(); tmin(); tmin();
    chk("R11 flag still set", flag, 1);
    chk("R11 no irq when disabled", irq_n, 1);
    chk("R4 min mode reload", count, 3);

    clr(); run = 0; sel = 0; cyc();
    t4k(); t4k(); t4k(); t4k(); t4k();
    chk("R8 halted count", count, 3);
    chk("R8 halted no event", flag, 0);

    irq_en = 1;
    run = 1; tick_4k = 1; cyc(); tick_4k = 0;
    chk("R3 tick on start ignored", count, 3);
    t4k(); t4k();
    flag_clr = 1; tick_4k = 1; cyc(); flag_clr = 0; tick_4k = 0;
    chk("R9 set beats clear", flag, 1);
    t128();

    run = 0; cyc();
    wr_preset(8'h00, 8'h00);
    clr();
    run = 1; cyc();
    chk("R7 zero preset load", count, 0);
    t4k();
    chk("R7 wrap to 4095", count, 4095);
    chk("R7 no event on wrap", flag, 0);
    repeat (4094) t4k();
    chk("R7 count before event", count, 1);
    t4k();
    chk("R7 event after 4096", flag, 1);
    chk("R7 reload zero", count, 0);

    cyc();
    finish_run();
  end
endmodule